// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block provides the modem side of a byte-oriented serial port. It holds a five-bit control register that drives four external handshake outputs (terminal-ready, request-to-send and two auxiliary outputs) and carries a loopback enable. It also provides a status register that shows the current level of four external handshake inputs (clear-to-send, data-set-ready, ring and carrier). For each input it records whether that input has changed since software last looked.

The inputs are asynchronous, so each one passes through a multi-stage synchroniser before its level is compared with the previous one. Any recorded change raises a modem-status interrupt condition. Reading the status register clears the recorded changes, but a change detected in the same cycle as that read is kept. When loopback is enabled, the status lines are taken from the control bits instead of the pins, and the external outputs hold their last values.

Access goes through a single byte-wide port. A one-bit register select chooses between the two registers. Writes take effect at the clock edge that samples them, and read data is registered.

Top module: `modem_line_unit`

## Requirements
- R1: After reset the control register reads 0x08, the auxiliary-2 output is 1 and the other three outputs are 0, `msi_pend` is 0, the status low nibble is 0 and the status high nibble shows the input levels.
- R2: The control register keeps only the low five bits of a write (bit0 terminal-ready, bit1 request-to-send, bit2 auxiliary-1, bit3 auxiliary-2, bit4 loopback). A read returns those bits with bits 7..5 at zero.
- R3: A control write with bit4 clear drives its bits 3..0 onto the four outputs at the same clock edge.
- R4: Status layout is bit7 carrier, bit6 ring, bit5 data-set-ready, bit4 clear-to-send. Bits 3, 1 and 0 latch any change of carrier, data-set-ready and clear-to-send respectively.
- R5: Status bit2 latches only a 1-to-0 transition of the ring line; a 0-to-1 transition records nothing.
- R6: A status read (register select 1) clears bits 3..0, and `msi_pend` falls on the following edge.
- R7: A line change detected in the same cycle as a status read is kept in the low nibble and keeps `msi_pend` high.
- R8: `msi_pend` is 1 exactly when any status bit 3..0 is set.
- R9: With loopback set, the status high nibble is taken from the control bits: auxiliary-2 to carrier, auxiliary-1 to ring, terminal-ready to data-set-ready, request-to-send to clear-to-send. External inputs then have no effect, and changes of these looped lines set the change bits by the R4 and R5 rules.
- R10: A control write with bit4 set leaves the four external outputs unchanged.
- R11: A write with register select 1 changes nothing.
- R12: An input change appears in the status high nibble after SYNC_STAGES clock edges, and its change bit and `msi_pend` are set one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| in_clear_send | input | 1 | Clear-to-send input, asynchronous |
| in_set_ready | input | 1 | Data-set-ready input, asynchronous |
| in_ring | input | 1 | Ring input, asynchronous |
| in_carrier | input | 1 | Carrier input, asynchronous |
| out_term_ready | output | 1 | Terminal-ready output |
| out_req_send | output | 1 | Request-to-send output |
| out_aux1 | output | 1 | Auxiliary output 1 |
| out_aux2 | output | 1 | Auxiliary output 2 |
| msi_pend | output | 1 | Modem-status interrupt condition |

## Verification
Read data is due one edge after the read strobe is sampled. Output pins are due at the edge that samples the write. A pin input change reaches the status high nibble two edges later and its change bit one edge after that. A control change in loopback reaches the change bits one edge after the write.

The driver changes inputs only at falling edges and queues each expected read value. The monitor compares each value just after the rising edge that registers it. Interrupt and pin checks are made at falling edges, counted from the stimulus edge. The same-cycle case times a read so that it lands on the edge where a change bit is set.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int DATA_W   = 8;
  localparam int LINE_CNT = 4;
  localparam int CTL_W    = 5;

  // line vector order equals status bit order minus LINE_CNT
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  localparam int CB_TERM = 0;
  localparam int CB_REQ  = 1;
  localparam int CB_AUX1 = 2;
  localparam int CB_AUX2 = 3;
  localparam int CB_LOOP = 4;

  localparam logic [CTL_W-1:0] CTL_RESET = 5'b01000;

  typedef enum logic {SEL_CTL = 1'b0, SEL_STS = 1'b1} reg_sel_e;

  function automatic logic [LINE_CNT-1:0] loop_lines(input logic [CTL_W-1:0] c);
    logic [LINE_CNT-1:0] l;
    l[LN_DCD] = c[CB_AUX2];
    l[LN_RI]  = c[CB_AUX1];
    l[LN_DSR] = c[CB_TERM];
    l[LN_CTS] = c[CB_REQ];
    return l;
  endfunction
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
  import modem_line_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ctl,
  input  logic [CTL_W-1:0]    wdata,
  output logic [CTL_W-1:0]    ctl,
  output logic [LINE_CNT-1:0] pins
);
  logic [CTL_W-1:0]    ctl_q;
  logic [LINE_CNT-1:0] pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      pins_q <= CTL_RESET[LINE_CNT-1:0];
    end else if (wr_ctl) begin
      ctl_q <= wdata;
      if (!wdata[CB_LOOP]) pins_q <= wdata[LINE_CNT-1:0];
    end
  end

  assign ctl  = ctl_q;
  assign pins = pins_q;

  // R3 and R10: pins move only on a control write with loopback clear
  a_r10_pins_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctl && !wdata[CB_LOOP]) |=> $stable(pins_q));
  a_r3_pins_follow: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wdata[CB_LOOP]) |=> (pins_q == $past(wdata[LINE_CNT-1:0])));
endmodule

// File: rtl/modem_line_sts.sv
module modem_line_sts
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LINE_CNT-1:0] ext_lines,
  input  logic [LINE_CNT-1:0] lb_lines,
  input  logic                lb_en,
  input  logic                clr_delta,
  output logic [LINE_CNT-1:0] lines,
  output logic [LINE_CNT-1:0] delta,
  output logic                irq
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);

  logic [CNT_W-1:0]    arm_cnt;
  logic                armed;
  logic [LINE_CNT-1:0] eff, prev_q, evt, delta_q, delta_d;
  logic                irq_q;

  assign eff   = lb_en ? lb_lines : ext_lines;
  assign armed = (arm_cnt == CNT_W'(SETTLE));

  for (genvar i = 0; i < LINE_CNT; i++) begin : g_evt
    if (i == LN_RI) begin : g_trail
      assign evt[i] = armed & prev_q[i] & ~eff[i];
    end else begin : g_any
      assign evt[i] = armed & (prev_q[i] ^ eff[i]);
    end
  end

  assign delta_d = (clr_delta ? '0 : delta_q) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt <= '0;
      prev_q  <= '0;
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
      prev_q  <= eff;
      delta_q <= delta_d;
      irq_q   <= |delta_d;
    end
  end

  assign lines = eff;
  assign delta = delta_q;
  assign irq   = irq_q;

  // R6: a read leaves only changes detected in that same cycle
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    clr_delta |=> ((delta_q & ~$past(evt)) == '0));
  // R5: ring rising never records a change
  a_r5_ring_rise_quiet: assert property (@(posedge clk) disable iff (rst)
    !prev_q[LN_RI] |=> !$rose(delta_q[LN_RI]));
  // R8: interrupt condition tracks the change bits
  a_r8_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|delta_q));
  // R7: a change at the read edge survives the clear
  a_r7_keep_on_read: assert property (@(posedge clk) disable iff (rst)
    (clr_delta && (|evt)) |=> irq_q);
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              in_clear_send,
  input  logic              in_set_ready,
  input  logic              in_ring,
  input  logic              in_carrier,
  output logic              out_term_ready,
  output logic              out_req_send,
  output logic              out_aux1,
  output logic              out_aux2,
  output logic              msi_pend
);
  logic [LINE_CNT-1:0] raw_lines, sync_lines, lines, delta, pins;
  logic [CTL_W-1:0]    ctl;
  logic                wr_ctl, rd_sts;
  logic [DATA_W-1:0]   rd_q;

  assign raw_lines[LN_CTS] = in_clear_send;
  assign raw_lines[LN_DSR] = in_set_ready;
  assign raw_lines[LN_RI]  = in_ring;
  assign raw_lines[LN_DCD] = in_carrier;

  assign wr_ctl = wr_en && (reg_sel == SEL_CTL);
  assign rd_sts = rd_en && (reg_sel == SEL_STS);

  modem_line_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_lines), .sync_out(sync_lines));

  modem_line_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(wr_data[CTL_W-1:0]),
    .ctl(ctl), .pins(pins));

  modem_line_sts #(.SYNC_STAGES(SYNC_STAGES)) u_sts (
    .clk(clk), .rst(rst), .ext_lines(sync_lines), .lb_lines(loop_lines(ctl)),
    .lb_en(ctl[CB_LOOP]), .clr_delta(rd_sts), .lines(lines), .delta(delta),
    .irq(msi_pend));

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en) begin
      if (reg_sel == SEL_STS) rd_q <= {lines, delta};
      else                    rd_q <= {{(DATA_W-CTL_W){1'b0}}, ctl};
    end
  end

  assign rd_data        = rd_q;
  assign out_term_ready = pins[CB_TERM];
  assign out_req_send   = pins[CB_REQ];
  assign out_aux1       = pins[CB_AUX1];
  assign out_aux2       = pins[CB_AUX2];

  // R2: control reads carry zeros above the kept field
  a_r2_ctl_read_upper: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == SEL_CTL) |=> (rd_q[DATA_W-1:CTL_W] == '0));
  // R11: a status-select write leaves the control register alone
  a_r11_sts_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == SEL_STS) |=> $stable(ctl));
endmodule

// File: tb/sim_modem_line_unit.sv
`timescale 1ns/1ps
module sim_modem_line_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
  logic o_term, o_req, o_aux1, o_aux2, msi;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  modem_line_unit u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .in_clear_send(cts),
    .in_set_ready(dsr), .in_ring(ri), .in_carrier(dcd),
    .out_term_ready(o_term), .out_req_send(o_req), .out_aux1(o_aux1),
    .out_aux2(o_aux2), .msi_pend(msi));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value right after the registering edge
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (exp_q.size() == 0) check("spurious read", rd_data, 8'hxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic do_read(input logic sel, input logic [7:0] exp, input string tag);
    reg_sel = sel; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_pins(input string tag, input logic [3:0] exp);
    check(tag, {4'h0, o_aux2, o_aux1, o_req, o_term}, {4'h0, exp});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    // R1 reset state
    do_read(1'b0, 8'h08, "R1 control reset");
    check_pins("R1 pins reset", 4'b1000);
    check("R1 msi reset", {7'h0, msi}, 8'h00);
    do_read(1'b1, 8'hB0, "R1 status reset");
    // R2 / R3 control write
    do_write(1'b0, 8'hE3);
    check_pins("R3 pins follow write", 4'b0011);
    do_read(1'b0, 8'h03, "R2 control low bits");
    // R11 status write ignored
    do_write(1'b1, 8'hFF);
    do_read(1'b1, 8'hB0, "R11 status after write");
    do_read(1'b0, 8'h03, "R11 control after status write");
    check("R11 msi", {7'h0, msi}, 8'h00);
    // R4 clear-to-send falls
    cts = 1'b0; settle();
    check("R8 msi on change", {7'h0, msi}, 8'h01);
    do_read(1'b1, 8'hA1, "R4 cts change");
    check("R6 msi cleared", {7'h0, msi}, 8'h00);
    do_read(1'b1, 8'hA0, "R6 deltas cleared");
    // R5 ring rises then falls
    ri = 1'b1; settle();
    check("R5 ring rise no msi", {7'h0, msi}, 8'h00);
    do_read(1'b1, 8'hE0, "R5 ring rise");
    ri = 1'b0; settle();
    do_read(1'b1, 8'hA4, "R5 ring trailing edge");
    do_read(1'b1, 8'hA0, "R6 ring delta cleared");
    // R4 carrier and data-set-ready fall together
    dcd = 1'b0; dsr = 1'b0; settle();
    do_read(1'b1, 8'h0A, "R4 dcd dsr change");
    do_read(1'b1, 8'h00, "R6 cleared again");
    // R12 / R7 latency and same-cycle retention
    cts = 1'b1;
    @(negedge clk);
    check("R12 msi not yet", {7'h0, msi}, 8'h00);
    @(negedge clk);
    do_read(1'b1, 8'h10, "R12 level visible, delta pending");
    check("R7 msi kept", {7'h0, msi}, 8'h01);
    do_read(1'b1, 8'h11, "R7 delta retained");
    // R9 / R10 loopback
    do_write(1'b0, 8'h1D);
    check_pins("R10 pins hold on loop write", 4'b0011);
    @(negedge clk);
    do_read(1'b1, 8'hEB, "R9 loop map and deltas");
    do_read(1'b1, 8'hE0, "R9 loop cleared");
    do_write(1'b0, 8'h12);
    check_pins("R10 pins hold second loop write", 4'b0011);
    @(negedge clk);
    do_read(1'b1, 8'h1F, "R9 loop lines fall");
    dcd = 1'b1; settle();
    do_read(1'b1, 8'h10, "R9 external ignored in loop");
    do_write(1'b0, 8'h00);
    check_pins("R3 pins after loop exit", 4'b0000);
    @(negedge clk);
    do_read(1'b1, 8'h98, "R9 back to external lines");
    do_read(1'b0, 8'h00, "R2 control after loop exit");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule